// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block decides when a DRAM must be refreshed and asks the access controller to run the cycles. A free-running interval timer produces one refresh slot per row period. Each slot adds one owed refresh. While refreshes are owed, the block raises a request marked as a CAS-before-RAS cycle. The controller grants it when the bus is free, and each grant retires one owed refresh. Refreshes may be postponed up to a parameterised backlog. When the backlog is full, an urgent flag is raised.

The block also watches whether refresh is spread evenly. An interval of `ROWS` slots counts as even when every slot's refresh was retired before the next slot arrived and the controller reported no row-addressed refresh of its own. The latest verdict is kept in a mode bit.

A low-power request moves the device into self refresh, and the mode bit decides the rules for entry and exit. With even refresh, entry is immediate and exit is followed by a single CBR cycle. Otherwise a burst of `ROWS` refreshes runs just before entry and again just after exit. The block guarantees a minimum residency in self refresh and a recovery gap after leaving it. Pin-level timing of every cycle belongs to the controller.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low and just after it: `ref_req`, `urgent`, `sr_enter`, `sr_exit`, `sr_active` and `even_mode` are 0.
- R2: After reset is released, the first refresh slot occurs on the `TICK_CYCLES`-th rising clock edge. From then on a slot occurs every `TICK_CYCLES` edges. In normal operation `ref_req` is 1 whenever at least one refresh is owed, with `ref_kind` = 0 (single CBR cycle). `ref_kind` = 1 marks a burst refresh and 2 marks the self-refresh entry cycle.
- R3: A refresh is granted on a rising edge where `ref_req` and `ref_gnt` are both 1. Each granted normal refresh retires one owed refresh. `ref_req` holds with a stable `ref_kind` until it is granted.
- R4: `urgent` is 1 exactly when the owed count equals `MAX_POSTPONE`. Further slots do not raise the count above `MAX_POSTPONE`.
- R5: At the end of every `ROWS`-slot interval, `even_mode` takes the value 1 if no slot in that interval found a refresh still owed, and 0 otherwise.
- R6: When `lp_req` is 1, nothing is owed and `even_mode` is 1, the next request is the entry cycle (`ref_kind` = 2) with no burst before it.
- R7: When `lp_req` is 1, nothing is owed and `even_mode` is 0, exactly `ROWS` burst requests (`ref_kind` = 1) come before the entry cycle.
- R8: One cycle after the entry cycle is granted, `sr_enter` pulses for one cycle and `sr_active` rises. No request is made while `sr_active` is 1.
- R9: `sr_active` stays 1 for at least `SR_MIN` cycles and, after that, for as long as `lp_req` stays 1. It falls in the cycle where `sr_exit` pulses.
- R10: After `sr_exit`, `ref_req` stays 0 for exactly `SR_REC` cycles, counting the `sr_exit` cycle.
- R11: If entry took place with `even_mode` 1, the exit sequence is exactly one request with `ref_kind` = 0, after which normal operation resumes with nothing owed.
- R12: If entry took place with `even_mode` 0, the exit sequence is exactly `ROWS` requests with `ref_kind` = 1, and `even_mode` remains 0 afterwards.
- R13: A pulse on `ext_row_refresh` makes the current interval uneven.
- R14: `lp_req` has no effect while a refresh is owed. The owed CBR request is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 1 | Request to enter and stay in self refresh |
| ref_gnt | input | 1 | Controller accepts the pending refresh request |
| ext_row_refresh | input | 1 | Controller performed a row-addressed refresh on its own |
| ref_req | output | 1 | Refresh cycle requested |
| ref_kind | output | 2 | 0 single CBR, 1 burst CBR, 2 self-refresh entry |
| urgent | output | 1 | Backlog of owed refreshes is full |
| sr_enter | output | 1 | One-cycle strobe: device is now in self refresh |
| sr_exit | output | 1 | One-cycle strobe: controller must raise RAS and leave self refresh |
| sr_active | output | 1 | Device is in self refresh |
| even_mode | output | 1 | Last full interval was refreshed evenly |

## Verification
The bench uses a small configuration of eight rows, a 20-cycle slot, a backlog of four, a 30-cycle minimum residency and a 5-cycle recovery. Expected counts and cycle offsets are computed from these values.

Refresh is driven under three patterns:
- **Promptly granted.** This must give an even verdict and keep it.
- **Disturbed by a single external row refresh.** This must spoil only the interval that contains it.
- **Withheld until the backlog saturates.** This separates a saturating counter from a wrapping one, and an `urgent` raised at the limit from one raised a slot early.

The low-power request is tried in three ways:
- In both modes, which tells single-cycle sequencing apart from burst sequencing.
- Held beyond the minimum residency and released early, which tells the minimum-time guard apart from plain tracking of `lp_req`.
- Raised while a refresh is still owed.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PRE_BURST,
        ST_ENTER,
        ST_SELF,
        ST_RECOVER,
        ST_POST_ONE,
        ST_POST_BURST
    } rfs_state_e;

    typedef enum logic [1:0] {
        KIND_CBR   = 2'd0,
        KIND_BURST = 2'd1,
        KIND_SELF  = 2'd2
    } rfs_kind_e;

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int TICK_CYCLES = 1950
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(TICK_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
    parameter int MAX_POSTPONE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic urgent
);
    localparam int DW = $clog2(MAX_POSTPONE + 1);
    localparam logic [DW-1:0] LIMIT = DW'(MAX_POSTPONE);

    logic [DW-1:0] debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        if (inc && !dec) begin
            if (debt_q != LIMIT) begin
                debt_d = debt_q + 1'b1;
            end
        end else if (dec && !inc && debt_q != '0) begin
            debt_d = debt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else begin
            debt_q <= debt_d;
        end
    end

    assign owed   = (debt_q != '0);
    assign urgent = (debt_q == LIMIT);
endmodule

// File: rtl/rfs_pattern_mon.sv
module rfs_pattern_mon #(
    parameter int ROWS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic late,
    input  logic disturb,
    input  logic restart,
    output logic even_mode
);
    localparam int IW = $clog2(ROWS);
    localparam logic [IW-1:0] LAST = IW'(ROWS - 1);

    typedef struct packed {
        logic [IW-1:0] ivl;
        logic          clean;
        logic          even;
    } mon_s;

    mon_s mon_d, mon_q;
    logic clean_now;

    always_comb begin
        mon_d     = mon_q;
        clean_now = mon_q.clean && !disturb && !(tick && late);
        if (restart) begin
            mon_d.ivl   = '0;
            mon_d.clean = 1'b1;
        end else begin
            mon_d.clean = clean_now;
            if (tick) begin
                if (mon_q.ivl == LAST) begin
                    mon_d.even  = clean_now;
                    mon_d.ivl   = '0;
                    mon_d.clean = 1'b1;
                end else begin
                    mon_d.ivl = mon_q.ivl + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '{ivl: '0, clean: 1'b1, even: 1'b0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign even_mode = mon_q.even;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int ROWS         = 2048,
    parameter int TICK_CYCLES  = 1950,
    parameter int MAX_POSTPONE = 8,
    parameter int SR_MIN       = 12500,
    parameter int SR_REC       = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_req,
    input  logic       ref_gnt,
    input  logic       ext_row_refresh,
    output logic       ref_req,
    output logic [1:0] ref_kind,
    output logic       urgent,
    output logic       sr_enter,
    output logic       sr_exit,
    output logic       sr_active,
    output logic       even_mode
);
    localparam int BW   = $clog2(ROWS);
    localparam int WMAX = (SR_MIN > SR_REC) ? SR_MIN : SR_REC;
    localparam int WW   = $clog2(WMAX + 1);
    localparam logic [BW-1:0] ROW_LAST = BW'(ROWS - 1);
    localparam logic [WW-1:0] MIN_LOAD = WW'(SR_MIN - 1);
    localparam logic [WW-1:0] REC_LOAD = WW'(SR_REC - 1);

    typedef struct packed {
        rfs_state_e    state;
        logic [BW-1:0] brc;
        logic [WW-1:0] wait_cnt;
        logic          sr_even;
        logic          enter_stb;
        logic          exit_stb;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic tick, owed, restart, in_run, tick_run, retire;

    assign in_run   = (ctl_q.state == ST_RUN);
    assign tick_run = tick && in_run;
    assign retire   = in_run && owed && ref_gnt;

    rfs_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfs_debt_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) i_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick_run),
        .dec    (retire),
        .owed   (owed),
        .urgent (urgent)
    );

    rfs_pattern_mon #(.ROWS(ROWS)) i_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_run),
        .late      (owed),
        .disturb   (ext_row_refresh),
        .restart   (restart),
        .even_mode (even_mode)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.enter_stb = 1'b0;
        ctl_d.exit_stb  = 1'b0;
        restart         = 1'b0;
        case (ctl_q.state)
            ST_RUN: begin
                if (lp_req && !owed && !tick) begin
                    if (even_mode) begin
                        ctl_d.state = ST_ENTER;
                    end else begin
                        ctl_d.state = ST_PRE_BURST;
                        ctl_d.brc   = ROW_LAST;
                    end
                end
            end
            ST_PRE_BURST: begin
                if (ref_gnt) begin
                    if (ctl_q.brc == '0) begin
                        ctl_d.state = ST_ENTER;
                    end else begin
                        ctl_d.brc = ctl_q.brc - 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                if (ref_gnt) begin
                    ctl_d.state     = ST_SELF;
                    ctl_d.wait_cnt  = MIN_LOAD;
                    ctl_d.sr_even   = even_mode;
                    ctl_d.enter_stb = 1'b1;
                end
            end
            ST_SELF: begin
                if (ctl_q.wait_cnt != '0) begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt - 1'b1;
                end else if (!lp_req) begin
                    ctl_d.state    = ST_RECOVER;
                    ctl_d.wait_cnt = REC_LOAD;
                    ctl_d.exit_stb = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (ctl_q.wait_cnt == '0) begin
                    if (ctl_q.sr_even) begin
                        ctl_d.state = ST_POST_ONE;
                    end else begin
                        ctl_d.state = ST_POST_BURST;
                        ctl_d.brc   = ROW_LAST;
                    end
                end else begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt - 1'b1;
                end
            end
            ST_POST_ONE: begin
                if (ref_gnt) begin
                    ctl_d.state = ST_RUN;
                    restart     = 1'b1;
                end
            end
            ST_POST_BURST: begin
                if (ref_gnt) begin
                    if (ctl_q.brc == '0) begin
                        ctl_d.state = ST_RUN;
                        restart     = 1'b1;
                    end else begin
                        ctl_d.brc = ctl_q.brc - 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN, brc: '0, wait_cnt: '0, sr_even: 1'b0,
                       enter_stb: 1'b0, exit_stb: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ref_req  = 1'b0;
        ref_kind = KIND_CBR;
        case (ctl_q.state)
            ST_RUN:        ref_req = owed;
            ST_POST_ONE:   ref_req = 1'b1;
            ST_PRE_BURST,
            ST_POST_BURST: begin
                ref_req  = 1'b1;
                ref_kind = KIND_BURST;
            end
            ST_ENTER: begin
                ref_req  = 1'b1;
                ref_kind = KIND_SELF;
            end
            default: ref_req = 1'b0;
        endcase
    end

    assign sr_enter  = ctl_q.enter_stb;
    assign sr_exit   = ctl_q.exit_stb;
    assign sr_active = (ctl_q.state == ST_SELF);
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int SR_MIN = 12500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_gnt,
    input logic       ref_req,
    input logic [1:0] ref_kind,
    input logic       urgent,
    input logic       sr_enter,
    input logic       sr_exit,
    input logic       sr_active
);
    localparam int CW = $clog2(SR_MIN + 1);
    localparam logic [CW-1:0] CAP = CW'(SR_MIN);

    logic [CW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !sr_active) begin
            act_q <= '0;
        end else if (act_q != CAP) begin
            act_q <= act_q + 1'b1;
        end
    end

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ref_kind != 2'd3); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> ref_req); // R3
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> $stable(ref_kind)); // R3
    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> ref_req); // R4
    AST_ENTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter |=> !sr_enter); // R8
    AST_ENTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter |-> sr_active); // R8
    AST_QUIET_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req); // R8
    AST_EXIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |-> !sr_active && $past(sr_active)); // R9
    AST_MIN_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |-> act_q == CAP); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_enter && sr_exit)); // R9
endmodule

bind dram_refresh_sched rfs_checker #(.SR_MIN(SR_MIN)) i_rfs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_gnt   (ref_gnt),
    .ref_req   (ref_req),
    .ref_kind  (ref_kind),
    .urgent    (urgent),
    .sr_enter  (sr_enter),
    .sr_exit   (sr_exit),
    .sr_active (sr_active)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int ROWS = 8;
    localparam int TCK  = 20;
    localparam int MAXP = 4;
    localparam int SMIN = 30;
    localparam int SREC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_req = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ext_row_refresh = 1'b0;
    logic       ref_req, urgent, sr_enter, sr_exit, sr_active, even_mode;
    logic [1:0] ref_kind;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .ROWS(ROWS), .TICK_CYCLES(TCK), .MAX_POSTPONE(MAXP),
        .SR_MIN(SMIN), .SR_REC(SREC)
    ) i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .ref_gnt(ref_gnt),
        .ext_row_refresh(ext_row_refresh), .ref_req(ref_req),
        .ref_kind(ref_kind), .urgent(urgent), .sr_enter(sr_enter),
        .sr_exit(sr_exit), .sr_active(sr_active), .even_mode(even_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Counts kinds granted until sr_enter appears.
    task automatic run_entry(output int k_burst, output int k_self);
        int guard;
        k_burst = 0;
        k_self  = 0;
        guard   = 0;
        while (!sr_enter && guard < 200) begin
            if (ref_req && ref_gnt) begin
                if (ref_kind == 2'd1) k_burst++;
                if (ref_kind == 2'd2) k_self++;
            end
            cyc(1);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        wrap_up();
    end

    initial begin
        int cnt, k1, k2, other, guard;
        bit seen0;

        // R1: reset state
        cyc(3);
        chk(!ref_req && !urgent && !sr_enter && !sr_exit && !sr_active && !even_mode,
            "R1 outputs idle in reset", int'(ref_req), 0);
        rst_n = 1'b1;
        cyc(TCK - 1);
        chk(!ref_req, "R2 no request before first slot", int'(ref_req), 0);
        chk(!even_mode && !sr_active, "R1 idle after reset", int'(even_mode), 0);
        cyc(1);
        chk(ref_req && ref_kind == 2'd0, "R2 request at first slot", int'(ref_req), 1);
        chk(!urgent, "R4 urgent low with one owed", int'(urgent), 0);
        ref_gnt = 1'b1;
        cyc(1);
        chk(!ref_req, "R3 grant retires request", int'(ref_req), 0);

        // R5: prompt service gives an even verdict that holds
        cyc(2 * ROWS * TCK + TCK);
        chk(even_mode, "R5 even after clean interval", int'(even_mode), 1);
        cnt = 0;
        for (int i = 0; i < 2 * ROWS * TCK; i++) begin
            cyc(1);
            if (!even_mode) cnt++;
        end
        chk(cnt == 0, "R5 even held under clean service", cnt, 0);

        // R13: external row refresh spoils one interval
        ext_row_refresh = 1'b1;
        cyc(1);
        ext_row_refresh = 1'b0;
        seen0 = 1'b0;
        for (int i = 0; i < ROWS * TCK + TCK; i++) begin
            cyc(1);
            if (!even_mode) seen0 = 1'b1;
        end
        chk(seen0, "R13 external refresh clears even", int'(seen0), 1);
        cyc(2 * ROWS * TCK + TCK);
        chk(even_mode, "R13 even regained", int'(even_mode), 1);

        // R14: low-power ignored while a refresh is owed
        ref_gnt = 1'b0;
        guard = 0;
        while (!ref_req && guard < 3 * TCK) begin
            cyc(1);
            guard++;
        end
        lp_req = 1'b1;
        cyc(5);
        chk(ref_req && ref_kind == 2'd0 && !sr_active, "R14 owed CBR served first",
            int'(ref_kind), 0);

        // R6, R8: even entry has no burst
        ref_gnt = 1'b1;
        run_entry(k1, k2);
        chk(k1 == 0, "R6 no burst before even entry", k1, 0);
        chk(k2 == 1, "R6 single entry cycle", k2, 1);
        chk(sr_enter && sr_active && !ref_req, "R8 enter strobe with active", int'(sr_active), 1);
        lp_req = 1'b0;
        cnt = 1;
        cyc(1);
        chk(!sr_enter, "R8 enter strobe one cycle", int'(sr_enter), 0);
        guard = 0;
        while (sr_active && guard < 200) begin
            cnt++;
            cyc(1);
            guard++;
        end
        chk(cnt == SMIN, "R9 minimum residency", cnt, SMIN);
        chk(sr_exit, "R9 exit strobe on fall", int'(sr_exit), 1);

        // R10: recovery gap
        cnt = 0;
        guard = 0;
        while (!ref_req && guard < 100) begin
            cnt++;
            cyc(1);
            guard++;
        end
        chk(cnt == SREC, "R10 recovery gap", cnt, SREC);

        // R11: single CBR after even exit
        chk(ref_kind == 2'd0, "R11 exit cycle is CBR", int'(ref_kind), 0);
        cyc(1);
        chk(!ref_req, "R11 only one exit cycle", int'(ref_req), 0);
        chk(even_mode && !sr_active, "R11 even retained", int'(even_mode), 1);

        // R4: backlog saturates and raises urgent
        ref_gnt = 1'b0;
        guard = 0;
        while (!ref_req && guard < 3 * TCK) begin
            cyc(1);
            guard++;
        end
        cnt = 0;
        while (!urgent && cnt < 10 * TCK) begin
            cyc(1);
            cnt++;
        end
        chk(cnt == 3 * TCK, "R4 urgent at limit", cnt, 3 * TCK);
        cyc(2 * TCK + 2);
        chk(urgent, "R4 urgent held while saturated", int'(urgent), 1);
        ref_gnt = 1'b1;
        cyc(1);
        chk(!urgent, "R4 urgent clears after one grant", int'(urgent), 0);
        cnt = 1;
        guard = 0;
        while (ref_req && guard < 20) begin
            cnt++;
            cyc(1);
            guard++;
        end
        chk(cnt == MAXP, "R4 backlog saturated at limit", cnt, MAXP);

        // R5: postponement makes the pattern uneven
        seen0 = 1'b0;
        for (int i = 0; i < ROWS * TCK + TCK; i++) begin
            cyc(1);
            if (!even_mode) begin
                seen0 = 1'b1;
                break;
            end
        end
        chk(seen0, "R5 postponed slot clears even", int'(seen0), 1);

        // R7: burst before uneven entry
        lp_req = 1'b1;
        run_entry(k1, k2);
        chk(k1 == ROWS, "R7 burst before uneven entry", k1, ROWS);
        chk(k2 == 1, "R7 entry after burst", k2, 1);

        // R9: residency follows lp_req beyond minimum
        cnt = 0;
        for (int i = 0; i < SMIN + 10; i++) begin
            cyc(1);
            if (sr_exit || !sr_active) cnt++;
        end
        chk(cnt == 0, "R9 stays while lp_req held", cnt, 0);
        lp_req = 1'b0;
        cyc(1);
        chk(sr_exit && !sr_active, "R9 exit one cycle after release", int'(sr_exit), 1);

        // R12: burst after uneven exit
        guard = 0;
        while (!ref_req && guard < 100) begin
            cyc(1);
            guard++;
        end
        k1 = 0;
        other = 0;
        guard = 0;
        while (ref_req && guard < 100) begin
            if (ref_kind == 2'd1) k1++;
            else other++;
            cyc(1);
            guard++;
        end
        chk(k1 == ROWS && other == 0, "R12 exit burst length", k1, ROWS);
        chk(!even_mode, "R12 uneven retained", int'(even_mode), 0);

        wrap_up();
    end
endmodule